// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is the clocked control front end of a synchronous burst SRAM, built around a behavioural word store with four byte lanes. On every rising clock edge it samples three chip enables, two address strobes, an advance input, the write controls and the address. From these it forms the word address of the cycle and the per-lane write strobes. Read data comes out one edge later and is gated by an output-enable input.

A burst starts with either strobe. The host-side strobe (`adsp_n`) only counts while `ce1_n` is low. The controller-side strobe (`adsc_n`) counts on its own. The two low address bits then run through a two-bit counter that `adv_n` steps in linear order, wrapping inside the four-word group. A global write overrides all byte qualification.

The data pins are plain signals, not a valid/ready stream. A memory pin interface has no back-pressure, so a read result simply occupies `dout` for the cycle after its access. The tri-state bus is modelled as `dout` with the enable `dout_en`, and `dout` is forced to zero whenever `dout_en` is low. `ADDR_W` defaults to 8 for a small store; 17 gives the full-size part.

Top module: `sram_burst_front`

## Requirements
- R1: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe edge (either `adsc_n`=0, or `adsp_n`=0 with `ce1_n`=0) while selected captures `addr` and starts a burst, with the access at `addr` in that cycle.
- R2: `adsp_n`=0 while `ce1_n`=1 has no effect. With `adsc_n`=1 that cycle behaves as a plain continuation of any running burst and neither captures nor deselects.
- R3: A strobe edge while not selected ends the burst. No read or write takes place until the next capture, and `dout_en` is low on the following cycle.
- R4: `addr[1:0]` loads a two-bit counter on capture. Each continuation cycle with `adv_n`=0 accesses counter+1 modulo 4, following 00,01,10,11 and wrapping to 00. The upper address bits are unchanged.
- R5: A continuation cycle with `adv_n`=1 accesses the same word as the previous cycle.
- R6: With `gw_n`=0 on a write-eligible access, all four lanes are written, whatever `bwe_n` and `bw_n` are.
- R7: With `gw_n`=1, lane i (bits 8i+7:8i of `wdata`) is written only if `bwe_n`=0 and `bw_n[i]`=0. With `gw_n`=1 and `bwe_n`=1 the cycle is a read.
- R8: A cycle that starts a burst through `adsp_n` is always a read; the write controls are ignored in it.
- R9: The word of a read access appears on `dout` after the next rising edge. An access with `gw_n`=0 or `bwe_n`=0 (not an `adsp_n` start) is a write and produces no read data.
- R10: `dout_en` = (`oe_n`=0 and the previous edge made a read). `dout` is 0 whenever `dout_en` is 0. After reset `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce1_n | input | 1 | Chip enable, active low; also qualifies `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adsp_n | input | 1 | Host-side address strobe, active low |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 4 | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| dout | output | 32 | Read data, zero when not driven |
| dout_en | output | 1 | High when the data bus is driven |

## Verification
A global-write burst fills a four-word group. A host-strobe read burst started in the middle of that group then shows whether the counter wraps at 11 rather than carrying into the upper bits. Byte-masked writes with changing select patterns, and a `bwe_n`-high cycle, separate per-lane qualification from global write. Host-strobe starts that carry write controls, host strobes with `ce1_n` high inside a running burst, deselecting strobes on each enable, `adv_n`-high holds and `oe_n` toggling separate the start, ignore, stop, hold and gating rules from one another.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  typedef enum logic [1:0] {
    CYC_NONE   = 2'd0,
    CYC_PSTART = 2'd1,
    CYC_CSTART = 2'd2,
    CYC_CONT   = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_fe_pkg::*;
(
  input  logic      ce1_n,
  input  logic      ce2,
  input  logic      ce3_n,
  input  logic      adsp_n,
  input  logic      adsc_n,
  input  logic      burst_on,
  output cyc_kind_e kind,
  output logic      dev_sel
);
  logic host_strobe;

  always_comb begin
    // host strobe only counts while ce1_n is low
    host_strobe = !adsp_n && !ce1_n;
    dev_sel     = !ce1_n && ce2 && !ce3_n;
    if (host_strobe)      kind = CYC_PSTART;
    else if (!adsc_n)     kind = CYC_CSTART;
    else if (burst_on)    kind = CYC_CONT;
    else                  kind = CYC_NONE;
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  cyc_kind_e               kind,
  input  logic                    dev_sel,
  input  logic                    adv_n,
  input  logic [ADDR_W-1:0]       addr_in,
  output logic [ADDR_W-1:0]       eff_addr,
  output logic                    access,
  output logic                    burst_on,
  output logic [CNT_W-1:0]        cnt_q,
  output logic [ADDR_W-CNT_W-1:0] base_q
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [CNT_W-1:0] cnt_step;
  logic             start;

  always_comb begin
    cnt_step = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    start    = (kind == CYC_PSTART) || (kind == CYC_CSTART);
    eff_addr = {base_q, cnt_q};
    access   = 1'b0;
    if (start) begin
      if (dev_sel) begin
        eff_addr = addr_in;
        access   = 1'b1;
      end
    end else if (kind == CYC_CONT) begin
      access   = 1'b1;
      eff_addr = adv_n ? {base_q, cnt_q} : {base_q, cnt_step};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
    end else begin
      if (start) burst_on <= dev_sel;
      if (access) begin
        base_q <= eff_addr[ADDR_W-1:CNT_W];
        cnt_q  <= eff_addr[CNT_W-1:0];
      end
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/sram_byte_wr.sv
module sram_byte_wr
  import sram_fe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             access,
  input  cyc_kind_e        kind,
  output logic [LANES-1:0] wstb,
  output logic             wr_cycle
);
  logic allow;

  assign allow    = access && (kind != CYC_PSTART);
  assign wr_cycle = allow && (!gw_n || !bwe_n);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wstb[i] = allow && (!gw_n || (!bwe_n && !bw_n[i]));
  end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wstb,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_en,
  output logic [LANES*LANE_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wstb[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
      if (rd_en)   q[i*LANE_W +: LANE_W] <= mem[waddr];
    end
  end
endmodule

// File: rtl/sram_burst_front.sv
module sram_burst_front
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int DATA_W = LANES * LANE_W;

  cyc_kind_e               kind;
  logic                    dev_sel;
  logic                    burst_on;
  logic [ADDR_W-1:0]       eff_addr;
  logic                    access;
  logic [CNT_W-1:0]        cnt_q;
  logic [ADDR_W-CNT_W-1:0] base_q;
  logic [LANES-1:0]        wstb;
  logic                    wr_cycle;
  logic                    rd_valid;
  logic [DATA_W-1:0]       q;

  sram_cycle_decode u_dec (
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .burst_on(burst_on),
    .kind(kind), .dev_sel(dev_sel)
  );

  sram_burst_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .kind(kind), .dev_sel(dev_sel),
    .adv_n(adv_n), .addr_in(addr), .eff_addr(eff_addr), .access(access),
    .burst_on(burst_on), .cnt_q(cnt_q), .base_q(base_q)
  );

  sram_byte_wr #(.LANES(LANES)) u_bw (
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .access(access),
    .kind(kind), .wstb(wstb), .wr_cycle(wr_cycle)
  );

  sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .wstb(wstb), .waddr(eff_addr), .wdata(wdata),
    .rd_en(access && !wr_cycle), .q(q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= access && !wr_cycle;
  end

  assign dout_en = !oe_n && rd_valid;
  assign dout    = dout_en ? q : '0;
endmodule

// File: rtl/sram_burst_front_chk.sv
module sram_burst_front_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce1_n,
  input logic                    ce2,
  input logic                    ce3_n,
  input logic                    adsp_n,
  input logic                    adsc_n,
  input logic                    adv_n,
  input logic                    gw_n,
  input logic                    bwe_n,
  input logic                    oe_n,
  input logic [LANES*LANE_W-1:0] dout,
  input logic                    dout_en,
  input logic                    burst_on,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [ADDR_W-CNT_W-1:0] base_q,
  input logic [LANES-1:0]        wstb
);
  logic p_hit, any_strobe, sel, no_start;
  assign p_hit      = !adsp_n && !ce1_n;
  assign any_strobe = p_hit || !adsc_n;
  assign sel        = !ce1_n && ce2 && !ce3_n;
  assign no_start   = !any_strobe;

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && sel) |=> burst_on);
  assert_adsp_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsp_n && ce1_n && adsc_n && burst_on) |=> burst_on);
  assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe && !sel) |=> (!burst_on && !dout_en));
  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && no_start && !adv_n) |=>
      (cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && $stable(base_q));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && no_start && adv_n) |=> ($stable(cnt_q) && $stable(base_q)));
  assert_global_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_on && no_start && !gw_n) |-> (&wstb));
  assert_no_byte_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> (wstb == '0));
  assert_adsp_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    p_hit |-> (wstb == '0));
  assert_write_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb != '0) |=> !dout_en);
  assert_oe_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n);
  assert_zero_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0));
endmodule

bind sram_burst_front sram_burst_front_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
  .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
  .bwe_n(bwe_n), .oe_n(oe_n), .dout(dout), .dout_en(dout_en),
  .burst_on(burst_on), .cnt_q(cnt_q), .base_q(base_q), .wstb(wstb)
);

// File: tb/tb_sram_burst_front.sv
`timescale 1ns/1ps
module tb_sram_burst_front;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n, oe_n;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   dout;
  logic          dout_en;

  always #2.5 clk = ~clk;

  sram_burst_front #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .dout(dout), .dout_en(dout_en)
  );

  // reference model state
  logic [31:0] ref_mem [0:(1<<AW)-1];
  int          m_cur;
  bit          m_on;
  bit          m_rdv;
  logic [31:0] m_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  task automatic quiet();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1; adv_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; addr = '0; wdata = '0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit p, strobe, sel, acc, wr;
    int ea;
    logic [31:0] mask;
    p = !adsp_n && !ce1_n;
    strobe = p || !adsc_n;
    sel = !ce1_n && ce2 && !ce3_n;
    acc = 0; ea = m_cur;
    if (strobe) begin
      m_on = sel;
      if (sel) begin acc = 1; ea = int'(addr); end
    end else if (m_on) begin
      acc = 1;
      ea = adv_n ? m_cur : ((m_cur & ~3) | ((m_cur + 1) & 3));
    end
    wr = acc && !p && (!gw_n || !bwe_n);
    if (wr) begin
      for (int i = 0; i < 4; i++)
        mask[i*8 +: 8] = (!gw_n || !bw_n[i]) ? 8'hFF : 8'h00;
      ref_mem[ea] = (ref_mem[ea] & ~mask) | (wdata & mask);
    end
    if (acc && !wr) m_q = ref_mem[ea];
    m_rdv = acc && !wr;
    if (acc) m_cur = ea;
  endtask

  // inputs already set by caller are applied for one clock; outputs compared first
  task automatic tick(input string tag);
    bit en;
    #1;
    en = !oe_n && m_rdv;
    check({tag, " dout_en"}, {31'd0, dout_en}, {31'd0, en});
    check({tag, " dout"}, dout, en ? m_q : 32'h0);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    m_cur = 0; m_on = 0; m_rdv = 0; m_q = '0;
    quiet();
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset dout_en", {31'd0, dout_en}, 32'd0);
    check("R10 reset dout", dout, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // clear the group at 0x10..0x13 and 0x20 with global writes (R6)
    quiet(); adsc_n = 0; addr = 8'h10; gw_n = 0; wdata = 32'hA0A0A0A0; tick("R6 R1 start write");
    quiet(); adv_n = 0; gw_n = 0; wdata = 32'hA1A1A1A1; tick("R6 R4 beat1");
    quiet(); adv_n = 0; gw_n = 0; bwe_n = 0; bw_n = 4'hF; wdata = 32'hA2A2A2A2; tick("R6 override");
    quiet(); adv_n = 0; gw_n = 0; wdata = 32'hA3A3A3A3; tick("R6 beat3");
    quiet(); adsc_n = 0; addr = 8'h20; gw_n = 0; wdata = 32'h11223344; tick("R6 write 0x20");

    // R4 R8 R9: host-strobe read burst from 0x12 wraps 12,13,10,11
    quiet(); adsp_n = 0; addr = 8'h12; gw_n = 0; wdata = 32'hDEADBEEF; tick("R8 adsp start ignores write");
    quiet(); adv_n = 0; tick("R9 R4 read 0x12");
    quiet(); adv_n = 0; tick("R4 read 0x13");
    quiet(); adv_n = 0; tick("R4 wrap read 0x10");
    quiet(); tick("R4 R5 read 0x11 hold");
    quiet(); tick("R5 hold again");

    // R7: byte-masked writes at 0x20
    quiet(); adsc_n = 0; addr = 8'h20; bwe_n = 0; bw_n = 4'b1010; wdata = 32'hCAFEF00D; tick("R7 mask 1010");
    quiet(); bwe_n = 0; bw_n = 4'b0111; wdata = 32'h5500AA99; tick("R7 mask 0111 R9 no data");
    quiet(); bwe_n = 1; bw_n = 4'b0000; wdata = 32'hFFFFFFFF; tick("R7 bwe high reads");
    quiet(); tick("R7 readback");
    quiet(); bwe_n = 0; bw_n = 4'hF; wdata = 32'h0; tick("R7 no lane selected");
    quiet(); tick("R7 readback2");

    // R2: host strobe with ce1_n high inside a burst continues the burst
    quiet(); adsc_n = 0; addr = 8'h11; tick("R1 read start 0x11");
    quiet(); ce1_n = 1; adsp_n = 0; addr = 8'h20; adv_n = 0; tick("R2 ignored adsp");
    quiet(); ce1_n = 1; adsp_n = 0; addr = 8'h20; adv_n = 0; tick("R2 ignored adsp again");
    quiet(); adv_n = 0; tick("R2 burst still running");
    quiet(); tick("R2 result");

    // R10: oe_n high hides data
    quiet(); oe_n = 1; tick("R10 oe high");
    quiet(); oe_n = 0; tick("R10 oe low");

    // R3: deselect through each enable
    quiet(); adsc_n = 0; ce2 = 0; tick("R3 deselect ce2");
    quiet(); adv_n = 0; gw_n = 0; wdata = 32'h99999999; tick("R3 no access");
    quiet(); tick("R3 still idle");
    quiet(); adsc_n = 0; addr = 8'h13; tick("R1 restart");
    quiet(); adsc_n = 0; ce3_n = 1; tick("R3 deselect ce3");
    quiet(); tick("R3 idle after ce3");
    quiet(); adsc_n = 0; addr = 8'h10; ce1_n = 1; tick("R3 deselect ce1 via adsc");
    quiet(); tick("R3 idle after ce1");

    // R1: strobe absent while idle does nothing
    quiet(); addr = 8'h12; tick("R1 no strobe");
    quiet(); adsp_n = 0; addr = 8'h10; tick("R1 R8 adsp read 0x10");
    quiet(); adsc_n = 0; adsp_n = 0; addr = 8'h13; gw_n = 0; wdata = 32'h77777777; tick("R8 both strobes read");
    quiet(); adv_n = 0; tick("R4 0x13 wraps to 0x10");
    quiet(); tick("R9 final");
    quiet(); tick("R9 final hold");

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule